// File: doc/BRIEF.md
# 128-by-64 Quotient Estimator

This unit estimates the 64-bit quotient of a 128-bit dividend, presented as a high word and a low word, by a 64-bit divisor whose top bit is set. Rather than running an exact bit-by-bit divider, it builds the answer from two 32-bit digits. Each digit is a trial quotient formed by dividing a 64-bit window by the divisor's upper half. The first digit is then checked against the full divisor and lowered when it is too large. The result is never below the true truncated quotient and never more than two above it. This is enough for a floating-point divide or square-root path that performs its own final remainder correction.

A caller presents the operands and raises `start` for one cycle while the unit is idle. The unit raises `busy` for the rest of the job and returns the estimate on `q` together with a one-cycle `done` pulse. If the high dividend word is already at or above the divisor, the quotient cannot fit in 64 bits. In that case the unit answers all ones on the next cycle without doing any arithmetic. The digit division and the divisor-by-digit multiply are iterative, one bit per cycle.

Top module: `qe_est`

## Requirements
- R1: While reset is applied, and until the first `start` after it, `busy` and `done` are 0 and `q` is 0.
- R2: A `start` accepted while idle with `b <= a_hi` gives `done` = 1 and `q` = all ones on the very next clock cycle, without `busy` ever rising.
- R3: For an accepted `start` with `b[63]` = 1 and `a_hi < b`, the returned `q` satisfies Q <= q <= Q + 2, where Q = floor((a_hi·2^64 + a_lo) / b).
- R4: `done` is high for exactly one cycle per accepted job, and `busy` is low whenever `done` is high.
- R5: Operands are captured only on an accepted `start`. A `start` raised while `busy` is high produces no extra result and does not alter the job in flight.
- R6: When b[63:32]·2^32 <= the 64-bit value being divided, a digit is 0xFFFFFFFF. Otherwise the digit is that value divided by b[63:32], truncated.
- R7: After the divisor times the upper digit (placed at bit 32) is subtracted from the dividend, the digit is decremented and b·2^32 is added back, once per cycle, while the 128-bit partial remainder is negative. The lower digit starts only from a non-negative remainder.
- R8: The lower digit divides bits 95:32 of the corrected remainder, and the running partial remainder inside the digit divider stays below b[63:32].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a job; accepted only when idle |
| a_hi | input | 64 | Upper word of the dividend |
| a_lo | input | 64 | Lower word of the dividend |
| b | input | 64 | Divisor, top bit must be set |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: `q` holds a new result |
| q | output | 64 | Quotient estimate |

## Verification
The assertions check several behaviours on every cycle. They cover the one-cycle shape of `done` and its exclusion with `busy`, and the freezing of captured operands during a job. They also check that the saturating answer arrives one cycle after `start`, that a digit saturates whenever the divisor's upper half reaches the numerator, that the divider's partial remainder stays below its divisor, and that the lower digit never starts from a negative remainder. Only the bench can show that the final estimate lands within two of the exact quotient. It compares the result against a 128-bit reference over random normalized divisors and over dividends just under the saturation limit. The bench also shows that a `start` raised mid-job yields no stray result.

// File: rtl/qe_pkg.sv
package qe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIVH,
    ST_MUL,
    ST_FIX,
    ST_DIVL
  } qe_state_t;
endpackage

// File: rtl/qe_digit_div.sv
// Iterative 2H/H restoring division producing one H-bit digit,
// saturating to all ones when the digit would not fit.
module qe_digit_div #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [2*HW-1:0] num,
  input  logic [HW-1:0]   den,
  output logic            rdy,
  output logic [HW-1:0]   quo
);
  localparam int CW = $clog2(HW + 1);

  logic          act_q, act_n;
  logic          rdy_q, rdy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [HW-1:0] part_q, part_n;
  logic [HW-1:0] low_q, low_n;
  logic [HW-1:0] den_q, den_n;
  logic [HW-1:0] quo_q, quo_n;
  logic [HW:0]   trial;
  logic          fits;
  logic          sat;

  always_comb begin
    trial = {part_q, low_q[HW-1]};
    fits  = trial >= {1'b0, den_q};
    sat   = {den, {HW{1'b0}}} <= num;
  end

  always_comb begin
    act_n  = act_q;
    rdy_n  = 1'b0;
    cnt_n  = cnt_q;
    part_n = part_q;
    low_n  = low_q;
    den_n  = den_q;
    quo_n  = quo_q;
    if (go) begin
      if (sat) begin
        quo_n = '1;
        rdy_n = 1'b1;
        act_n = 1'b0;
      end else begin
        act_n  = 1'b1;
        part_n = num[2*HW-1:HW];
        low_n  = num[HW-1:0];
        den_n  = den;
        cnt_n  = CW'(HW);
        quo_n  = '0;
      end
    end else if (act_q) begin
      part_n = fits ? (trial[HW-1:0] - den_q) : trial[HW-1:0];
      low_n  = {low_q[HW-2:0], 1'b0};
      quo_n  = {quo_q[HW-2:0], fits};
      cnt_n  = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        act_n = 1'b0;
        rdy_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
      part_q <= '0;
      low_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      act_q  <= act_n;
      rdy_q  <= rdy_n;
      cnt_q  <= cnt_n;
      part_q <= part_n;
      low_q  <= low_n;
      den_q  <= den_n;
      quo_q  <= quo_n;
    end
  end

  assign rdy = rdy_q;
  assign quo = quo_q;

  // R6
  digit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ({den, {HW{1'b0}}} <= num)) |=> (rdy && (&quo)));

  // R8
  part_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (part_q < den_q));

  // R4
  div_rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
endmodule

// File: rtl/qe_mul.sv
// Iterative shift-and-add multiply of an AW-bit operand by a BW-bit digit.
module qe_mul #(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    m,
  output logic             rdy,
  output logic [AW+BW-1:0] prod
);
  localparam int PW = AW + BW;
  localparam int CW = $clog2(BW + 1);

  logic          act_q, act_n;
  logic          rdy_q, rdy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [PW-1:0] acc_q, acc_n;
  logic [PW-1:0] mc_q, mc_n;
  logic [BW-1:0] mp_q, mp_n;

  always_comb begin
    act_n = act_q;
    rdy_n = 1'b0;
    cnt_n = cnt_q;
    acc_n = acc_q;
    mc_n  = mc_q;
    mp_n  = mp_q;
    if (go) begin
      act_n = 1'b1;
      cnt_n = CW'(BW);
      acc_n = '0;
      mc_n  = {{BW{1'b0}}, a};
      mp_n  = m;
    end else if (act_q) begin
      if (mp_q[0]) acc_n = acc_q + mc_q;
      mc_n  = {mc_q[PW-2:0], 1'b0};
      mp_n  = {1'b0, mp_q[BW-1:1]};
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        act_n = 1'b0;
        rdy_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
    end else begin
      act_q <= act_n;
      rdy_q <= rdy_n;
      cnt_q <= cnt_n;
      acc_q <= acc_n;
      mc_q  <= mc_n;
      mp_q  <= mp_n;
    end
  end

  assign rdy  = rdy_q;
  assign prod = acc_q;

  // R7
  mul_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !act_q);
endmodule

// File: rtl/qe_est.sv
module qe_est #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] a_lo,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] q
);
  import qe_pkg::*;

  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  logic [1:0]   rst_sync;
  logic         rst_ns;

  qe_state_t    state_q, state_n;
  logic [W-1:0] ahi_q, ahi_n;
  logic [W-1:0] alo_q, alo_n;
  logic [W-1:0] b_q, b_n;
  logic [H-1:0] zhi_q, zhi_n;
  logic [DW-1:0] rem_q, rem_n;
  logic [W-1:0] q_q, q_n;
  logic         done_q, done_n;

  logic         idle;
  logic         sat_in;
  logic         div_go, div_rdy;
  logic [W-1:0] div_num;
  logic [H-1:0] div_den, div_quo;
  logic         mul_go, mul_rdy;
  logic [W+H-1:0] mul_prod;
  logic [DW-1:0] b_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  always_comb begin
    idle    = (state_q == ST_IDLE);
    sat_in  = (b <= a_hi);
    div_go  = (idle && start && !sat_in) ||
              ((state_q == ST_FIX) && !rem_q[DW-1]);
    div_num = idle ? a_hi : rem_q[W+H-1:H];
    div_den = idle ? b[W-1:H] : b_q[W-1:H];
    mul_go  = (state_q == ST_DIVH) && div_rdy;
    b_up    = {{H{1'b0}}, b_q, {H{1'b0}}};
  end

  qe_digit_div #(.HW(H)) u_div (
    .clk  (clk),
    .rst_n(rst_ns),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .rdy  (div_rdy),
    .quo  (div_quo)
  );

  qe_mul #(.AW(W), .BW(H)) u_mul (
    .clk  (clk),
    .rst_n(rst_ns),
    .go   (mul_go),
    .a    (b_q),
    .m    (div_quo),
    .rdy  (mul_rdy),
    .prod (mul_prod)
  );

  always_comb begin
    state_n = state_q;
    ahi_n   = ahi_q;
    alo_n   = alo_q;
    b_n     = b_q;
    zhi_n   = zhi_q;
    rem_n   = rem_q;
    q_n     = q_q;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          ahi_n = a_hi;
          alo_n = a_lo;
          b_n   = b;
          if (sat_in) begin
            q_n    = '1;
            done_n = 1'b1;
          end else begin
            state_n = ST_DIVH;
          end
        end
      end
      ST_DIVH: begin
        if (div_rdy) begin
          zhi_n   = div_quo;
          state_n = ST_MUL;
        end
      end
      ST_MUL: begin
        if (mul_rdy) begin
          rem_n   = {ahi_q, alo_q} - {mul_prod, {H{1'b0}}};
          state_n = ST_FIX;
        end
      end
      ST_FIX: begin
        if (rem_q[DW-1]) begin
          rem_n = rem_q + b_up;
          zhi_n = zhi_q - H'(1);
        end else begin
          state_n = ST_DIVL;
        end
      end
      ST_DIVL: begin
        if (div_rdy) begin
          q_n     = {zhi_q, div_quo};
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      ahi_q   <= '0;
      alo_q   <= '0;
      b_q     <= '0;
      zhi_q   <= '0;
      rem_q   <= '0;
      q_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ahi_q   <= ahi_n;
      alo_q   <= alo_n;
      b_q     <= b_n;
      zhi_q   <= zhi_n;
      rem_q   <= rem_n;
      q_q     <= q_n;
      done_q  <= done_n;
    end
  end

  assign busy = !idle;
  assign done = done_q;
  assign q    = q_q;

  // R2
  early_sat_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (idle && start && (b <= a_hi)) |=> (done && (&q) && !busy));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> !busy);

  // R5
  operands_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |=> ($stable(ahi_q) && $stable(alo_q) && $stable(b_q)));

  // R7
  low_digit_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_DIVL) |-> !rem_q[DW-1]);
endmodule

// File: tb/qe_est_tb.sv
`timescale 1ns/1ps
module qe_est_tb;
  typedef struct packed {
    logic [63:0] ah;
    logic [63:0] al;
    logic [63:0] bb;
  } job_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] a_hi, a_lo, b;
  logic        busy, done;
  logic [63:0] q;

  int   n_chk  = 0;
  int   n_fail = 0;
  job_t sb[$];

  always #2.5 clk = ~clk;

  qe_est u_dut (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .a_hi (a_hi),
    .a_lo (a_lo),
    .b    (b),
    .busy (busy),
    .done (done),
    .q    (q)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every result pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 result with no accepted job", q, 64'h0);
      end else begin
        job_t j;
        logic [127:0] qx;
        j = sb.pop_front();
        chk(busy == 1'b0, "R4 busy low with done", {63'b0, busy}, 64'h0);
        if (j.bb <= j.ah) begin
          chk(&q, "R2 saturated quotient", q, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          qx = {j.ah, j.al} / {64'h0, j.bb};
          chk((q >= qx[63:0]) && ((q - qx[63:0]) <= 64'd2),
              "R3 estimate bound (expected = exact floor)", q, qx[63:0]);
        end
      end
    end
  end

  task automatic run_job(input logic [63:0] ah, input logic [63:0] al,
                         input logic [63:0] bb);
    job_t j;
    j.ah = ah; j.al = al; j.bb = bb;
    sb.push_back(j);
    a_hi = ah; a_lo = al; b = bb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bb <= ah)
      chk(done == 1'b1 && busy == 1'b0, "R2 one-cycle saturation latency",
          {62'b0, done, busy}, 64'h2);
    else
      chk(busy == 1'b1, "R3 job started", {63'b0, busy}, 64'h1);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] bb, ah;
    rst_n = 1'b0; start = 1'b0; a_hi = '0; a_lo = '0; b = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {62'b0, busy, done}, 64'h0);
    chk(q == 64'h0, "R1 q in reset", q, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags after reset", {62'b0, busy, done}, 64'h0);

    // Edge cases near saturation and at digit boundaries (R3, R6, R7)
    bb = rnd64() | 64'h8000_0000_0000_0000;
    run_job(bb - 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, bb);
    run_job(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    run_job(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run_job(64'h0, 64'h0, 64'h8000_0000_0000_0000);
    run_job(64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_FFFF_FFFF);       // R6 upper digit saturates
    run_job(64'h8000_0000_FFFF_FFFE, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000_FFFF_FFFF);
    run_job(64'h0000_0000_0000_0001, rnd64(), 64'hC000_0000_0000_0001);
    run_job(64'hABCD_0000_1234_5678, 64'h0, 64'hABCD_0001_0000_0000);       // R8 lower digit path

    // Saturation cases (R2)
    run_job(64'h9000_0000_0000_0000, rnd64(), 64'h9000_0000_0000_0000);
    run_job(64'hFFFF_FFFF_FFFF_FFFF, rnd64(), 64'h8000_0000_0000_0000);

    // R5: start raised while busy is ignored
    begin
      job_t j;
      j.ah = 64'h1234_5678_9ABC_DEF0; j.al = 64'h0FED_CBA9_8765_4321;
      j.bb = 64'hF000_0000_0000_0003;
      sb.push_back(j);
      a_hi = j.ah; a_lo = j.al; b = j.bb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      a_hi = 64'hFFFF_FFFF_FFFF_FFFF; a_lo = '0; b = 64'h8000_0000_0000_0000;
      start = 1'b1;
      repeat (2) @(negedge clk);
      start = 1'b0;
      a_hi = '0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(sb.size() == 0 && done == 1'b0, "R5 single result for mid-job start",
          64'(sb.size()), 64'h0);
    end

    // Random normalized divisors (R3)
    for (int i = 0; i < 150; i++) begin
      bb = rnd64() | 64'h8000_0000_0000_0000;
      ah = rnd64();
      if (ah >= bb) ah = ah - bb;
      if (i % 5 == 0) ah = bb - 64'(1 + ($urandom() % 4));
      run_job(ah, rnd64(), bb);
    end

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R4 every job completed once", 64'(sb.size()), 64'h0);
    summary();
    $finish;
  end
endmodule